// File: doc/BRIEF.md
# Two-Phase Handshake Occupancy Monitor

This block is a clocked companion for a transition-signalled pipeline stage. It samples the two outer handshake wires of the stage: the incoming request, which announces that an item enters, and the outgoing acknowledge, which announces that an item has left. Every change of level on a wire is one event, whichever way the wire moves. The block keeps a running count of the items held in the stage and reports it on its occupancy output.

The count may range from zero to a parameterised ceiling, which is 3 by default. An event that would push the count outside that range is a protocol violation. Such an event leaves the count unchanged and sets one of two error flags, overflow or underflow. Both flags hold their value until reset. A request event and an acknowledge event seen in the same clock cancel out. The pair is legal only when the stage is neither empty nor full. The monitor sits next to the latch controller and lets a testbench or an integration check find handshake misuse without looking inside the stage.

Top module: `hs_occ_monitor`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) sets occupancy to 0 and clears both error flags. The first sample after reset takes the wires' reset level to be 0.
- R2: A request-only event while occupancy is below DEPTH raises occupancy by exactly one at the next rising edge. This holds for a 0-to-1 change and for a 1-to-0 change of req_lvl.
- R3: A request-only event while occupancy equals DEPTH leaves occupancy unchanged and sets ovf_err at the next edge.
- R4: An acknowledge-only event while occupancy is above 0 lowers occupancy by exactly one at the next edge.
- R5: An acknowledge-only event while occupancy is 0 leaves occupancy unchanged and sets unf_err at the next edge.
- R6: A request event and an acknowledge event in the same clock, with occupancy between 1 and DEPTH-1, leave occupancy unchanged and set no flag.
- R7: A simultaneous pair at occupancy 0 keeps occupancy at 0 and sets unf_err. A simultaneous pair at occupancy DEPTH keeps occupancy at DEPTH and sets ovf_err.
- R8: Once set, ovf_err and unf_err stay set through any later events, legal or not, until the next reset.
- R9: An event is a difference between a wire's level and the level it had at the previous rising edge. A clock with neither wire changed leaves occupancy unchanged.
- R10: Occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lvl | input | 1 | Level of the stage's incoming request wire |
| ack_lvl | input | 1 | Level of the stage's outgoing acknowledge wire |
| occ | output | CNT_W ($clog2(DEPTH+1)) | Current item count |
| ovf_err | output | 1 | Sticky flag: a request arrived while full |
| unf_err | output | 1 | Sticky flag: an acknowledge arrived while empty |

## Verification
A wrong count does not stay hidden. It appears on occ one edge after the event, and later it produces false flags. A count that is one too high raises ovf_err one request too early, and a count that is one too low raises unf_err on an acknowledge that should have been legal. A stale copy of a wire shows up as a phantom step or a missed step in the very next cycle. The bench therefore compares the count and both flags after every single stimulus cycle, not only at the end of a sequence.

// File: rtl/hs_occ_pkg.sv
`timescale 1ns/1ps
// Package: shared event type for the occupancy monitor.
// Assumes nothing beyond a two-wire handshake, one wire per direction.
package hs_occ_pkg;

    // Kind of handshake activity seen in one sampling clock.
    typedef enum logic [1:0] {
        EV_NONE  = 2'b00,
        EV_FILL  = 2'b01,
        EV_DRAIN = 2'b10,
        EV_BOTH  = 2'b11
    } ev_kind_t;

    // Map the per-wire toggle indications to an event kind.
    function automatic ev_kind_t classify_ev(input logic fill_tgl, input logic drain_tgl);
        ev_kind_t k;
        unique case ({drain_tgl, fill_tgl})
            2'b01:   k = EV_FILL;
            2'b10:   k = EV_DRAIN;
            2'b11:   k = EV_BOTH;
            default: k = EV_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/hs_toggle_det.sv
`timescale 1ns/1ps
// Module: hs_toggle_det
// Flags a change of level on each of N wires. Each wire is compared with
// its own copy registered at the previous rising edge.
// Assumes the wires are already synchronous to clk. On reset, every copy
// takes the level 0.
module hs_toggle_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] tgl
);

    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_wire
        // Hold the level of wire g as it was at the last edge.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl[g];
        end

        // Wire g toggled since the last edge.
        assign tgl[g] = lvl[g] ^ lvl_q[g];
    end

endmodule

// File: rtl/hs_occ_track.sv
`timescale 1ns/1ps
// Module: hs_occ_track
// Keeps the occupancy count within 0..DEPTH. It flags an event that would
// leave that range and does not apply it.
// Assumes at most one fill and one drain event per clock.
module hs_occ_track
    import hs_occ_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ev_kind_t         ev,
    output logic [CNT_W-1:0] occ,
    output logic             ovf_hit,
    output logic             unf_hit
);

    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] EMPTY = '0;
    localparam logic [CNT_W-1:0] STEP  = CNT_W'(1);

    logic [CNT_W-1:0] occ_nxt;
    logic             is_full;
    logic             is_empty;

    assign is_full  = (occ == FULL);
    assign is_empty = (occ == EMPTY);

    // Work out the next count and any range violation for this clock.
    always_comb begin
        occ_nxt = occ;
        ovf_hit = 1'b0;
        unf_hit = 1'b0;
        unique case (ev)
            EV_FILL: begin
                if (is_full) ovf_hit = 1'b1;
                else         occ_nxt = occ + STEP;
            end
            EV_DRAIN: begin
                if (is_empty) unf_hit = 1'b1;
                else          occ_nxt = occ - STEP;
            end
            EV_BOTH: begin
                ovf_hit = is_full;
                unf_hit = is_empty;
            end
            default: occ_nxt = occ;
        endcase
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= EMPTY;
        else        occ <= occ_nxt;
    end

endmodule

// File: rtl/hs_err_latch.sv
`timescale 1ns/1ps
// Module: hs_err_latch
// Sticky error flags. A hit pulse sets its flag, and only reset clears it.
// Assumes the hit pulses are single-cycle and synchronous to clk.
module hs_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_hit,
    input  logic unf_hit,
    output logic ovf_err,
    output logic unf_err
);

    // Accumulate violations until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            ovf_err <= ovf_err | ovf_hit;
            unf_err <= unf_err | unf_hit;
        end
    end

endmodule

// File: rtl/hs_occ_monitor.sv
`timescale 1ns/1ps
// Module: hs_occ_monitor (top)
// Tracks how many items a two-phase pipeline stage holds by watching its
// request-in and acknowledge-out wires, and flags protocol violations.
// Assumes both wires are synchronous to clk and held low during reset.
module hs_occ_monitor
    import hs_occ_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_lvl,
    input  logic             ack_lvl,
    output logic [CNT_W-1:0] occ,
    output logic             ovf_err,
    output logic             unf_err
);

    logic [1:0] tgl;
    ev_kind_t   ev;
    logic       ovf_hit;
    logic       unf_hit;

    hs_toggle_det #(.N(2)) det_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({ack_lvl, req_lvl}),
        .tgl   (tgl)
    );

    // Combine the two toggle bits into one event kind.
    assign ev = classify_ev(tgl[0], tgl[1]);

    hs_occ_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .occ     (occ),
        .ovf_hit (ovf_hit),
        .unf_hit (unf_hit)
    );

    hs_err_latch err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_hit (ovf_hit),
        .unf_hit (unf_hit),
        .ovf_err (ovf_err),
        .unf_err (unf_err)
    );

endmodule

// File: rtl/hs_occ_monitor_chk.sv
`timescale 1ns/1ps
// Module: hs_occ_monitor_chk
// Property checker for hs_occ_monitor, bound to it. It detects events with
// its own copies of the wires, so it works from the ports only.
module hs_occ_monitor_chk #(
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_lvl,
    input logic             ack_lvl,
    input logic [CNT_W-1:0] occ,
    input logic             ovf_err,
    input logic             unf_err
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic req_q, ack_q;
    logic rq, ak;

    // Keep the checker's own copy of the wire levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            req_q <= req_lvl;
            ack_q <= ack_lvl;
        end
    end

    assign rq = req_lvl ^ req_q;
    assign ak = ack_lvl ^ ack_q;

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && !ak && occ < FULL) |=> occ == $past(occ) + ONE);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && !ak && occ == FULL) |=> (ovf_err && $stable(occ)));

    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ak && !rq && occ != '0) |=> occ == $past(occ) - ONE);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ak && !rq && occ == '0) |=> (unf_err && $stable(occ)));

    p_pair_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && ak && occ != '0 && occ != FULL && !ovf_err && !unf_err)
        |=> ($stable(occ) && !ovf_err && !unf_err));

    p_pair_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && ak && occ == '0) |=> (unf_err && occ == '0));

    p_pair_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rq && ak && occ == FULL) |=> (ovf_err && occ == FULL));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rq && !ak) |=> $stable(occ));

    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL);

endmodule

bind hs_occ_monitor hs_occ_monitor_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_lvl (req_lvl),
    .ack_lvl (ack_lvl),
    .occ     (occ),
    .ovf_err (ovf_err),
    .unf_err (unf_err)
);

// File: tb/hs_occ_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench for hs_occ_monitor: directed corner cases, then seeded random
// events. Every cycle is compared with a reference model.
module hs_occ_monitor_tb_top;

    localparam int DEPTH = 3;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_lvl = 1'b0;
    logic             ack_lvl = 1'b0;
    logic [CNT_W-1:0] occ;
    logic             ovf_err;
    logic             unf_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  m_occ  = 0;
    bit  m_ovf  = 0;
    bit  m_unf  = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    hs_occ_monitor #(.DEPTH(DEPTH)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_lvl (req_lvl),
        .ack_lvl (ack_lvl),
        .occ     (occ),
        .ovf_err (ovf_err),
        .unf_err (unf_err)
    );

    // Next count predicted by the model.
    function automatic int next_occ(int o, bit r, bit a);
        if (r && !a && o < DEPTH) return o + 1;
        if (a && !r && o > 0)     return o - 1;
        return o;
    endfunction

    function automatic bit ovf_hit(int o, bit r, bit a);
        return r && o == DEPTH && (!a || o != 0);
    endfunction

    function automatic bit unf_hit(int o, bit r, bit a);
        return a && o == 0;
    endfunction

    // Requirement that a given stimulus exercises.
    function automatic string req_tag(int o, bit r, bit a);
        if (r && a) return (o == 0 || o == DEPTH) ? "R7" : "R6";
        if (r)      return (o == DEPTH) ? "R3" : "R2";
        if (a)      return (o == 0) ? "R5" : "R4";
        return "R9";
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, int'(occ), m_occ, "occ");
        check(tag, int'(ovf_err), int'(m_ovf), "ovf_err");
        check(tag, int'(unf_err), int'(m_unf), "unf_err");
        check("R10", int'(occ <= DEPTH), 1, "occ within range");
        if (m_ovf || m_unf) check("R8", int'(ovf_err | unf_err), 1, "sticky flag");
    endtask

    // Apply one clock of stimulus at a falling edge; check at the next one.
    task automatic step(bit r, bit a);
        string tag;
        tag = req_tag(m_occ, r, a);
        if (r) req_lvl = ~req_lvl;
        if (a) ack_lvl = ~ack_lvl;
        m_ovf = m_ovf | ovf_hit(m_occ, r, a);
        m_unf = m_unf | unf_hit(m_occ, r, a);
        m_occ = next_occ(m_occ, r, a);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        req_lvl = 1'b0;
        ack_lvl = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_occ = 0;
        m_ovf = 0;
        m_unf = 0;
        check_all("R1");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2 filling to full, then R3 overflow.
        repeat (DEPTH) step(1, 0);
        step(1, 0);
        // R8 the flag stays through legal draining and R4.
        repeat (DEPTH) step(0, 1);
        step(0, 0);
        do_reset();

        // R5 underflow from empty.
        step(0, 1);
        step(1, 0);
        do_reset();

        // R6 simultaneous pairs in the middle range.
        step(1, 0);
        step(1, 1);
        step(1, 0);
        step(1, 1);
        // R7 pair while full.
        step(1, 0);
        step(1, 1);
        do_reset();

        // R7 pair while empty; R9 idle clocks.
        step(1, 1);
        repeat (3) step(0, 0);
        do_reset();

        // Random phase with an occasional reset.
        for (int i = 0; i < 800; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0 && ($urandom_range(0, 19) == 0)) do_reset();
            else if (sel < 4) step(1, 0);
            else if (sel < 7) step(0, 1);
            else if (sel < 9) step(1, 1);
            else              step(0, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule